// File: doc/BRIEF.md
# Program RAM Boot Loader Controller

This block sits in front of a small program RAM. After reset it takes control of the RAM write port and stores one byte per clock cycle. The address comes from a 5-bit pin bus and the data from an 8-bit pin bus. The processor core is held idle during this time, with its program counter at zero.

Once the mode pin is driven high, the block hands the RAM port to the core. The core then starts fetching from address 0. From then on the RAM port carries the core's own write enable, address and data, and the external pins have no effect. Only a reset puts the block back into loading.

The RAM port is registered. Each port value reaches the RAM one cycle after the clock edge that selected it. The mode pin passes through a parameterised chain of flip-flops (one stage by default) before it can change the phase.

Top module: `boot_load_ctrl`

## Requirements
- R1: When rst_n is low at a rising clock edge, the following cycle shows run_en=0, ram_we=0, ram_addr=0 and ram_wdata=0, and the block is in the loading phase.
- R2: While loading, run_en stays 0 for as long as the registered mode level is low.
- R3: In the loading phase, the port registers present after each edge are ram_we=1, ram_addr equal to ext_addr and ram_wdata equal to ext_data, all as sampled at that edge.
- R4: Back-to-back loading cycles each produce a write with fresh address and data. While loading, the core port inputs (core_we, core_addr, core_wdata) have no effect on the RAM port.
- R5: If mode_sel is sampled high at edge n, run_en reads 1 after edge n+1, so a one-cycle pulse is enough. Edge n+1 still performs a loading write from the pins. While run_en is 0 the core is held idle with its program counter at 0, and its first cycle with run_en=1 is the fetch from address 0.
- R6: While running, the port registers present after each edge are ram_we, ram_addr and ram_wdata equal to core_we, core_addr and core_wdata as sampled at that edge.
- R7: While running, ext_addr and ext_data have no effect on the RAM port.
- R8: Driving mode_sel low while running does not return the block to loading: run_en stays 1.
- R9: A reset while running returns the block to loading. From the first edge after reset is released, pin writes resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Level: low keeps loading, high releases the core |
| ext_addr | input | 5 | Write address from pins while loading |
| ext_data | input | 8 | Write data from pins while loading |
| core_we | input | 1 | Core RAM write enable |
| core_addr | input | 5 | Core RAM address |
| core_wdata | input | 8 | Core RAM write data |
| run_en | output | 1 | High once the core may run; low holds it idle with PC at 0 |
| ram_we | output | 1 | Registered RAM write enable |
| ram_addr | output | 5 | Registered RAM address |
| ram_wdata | output | 8 | Registered RAM write data |

## Verification
The assertions take for granted that rst_n is a synchronous input that is low at the first clock edge, and that all other inputs settle well before each rising edge. The bench meets this by holding rst_n low from time zero and changing every input only on falling edges. The pass-through properties do not constrain the core port values, so the stimulus drives arbitrary core and pin values in both phases. This includes core write enables while loading and pin activity while running.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } boot_phase_e;
endpackage

// File: rtl/boot_mode_sync.sv
module boot_mode_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin,
  output logic mode_q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= mode_pin;
      end
      assign mode_q = stage_q;

      // R5: a single stage follows the pin with one cycle of delay
      a_r5_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mode_q == $past(mode_pin)));
    end else begin : g_many
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], mode_pin};
      end
      assign mode_q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/boot_phase_fsm.sv
module boot_phase_fsm
  import boot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_q,
  output boot_phase_e phase,
  output logic        run_en
);
  boot_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
    end else begin
      unique case (phase_q)
        PH_LOAD: if (mode_q) phase_q <= PH_RUN;
        PH_RUN:  phase_q <= PH_RUN;
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign phase  = phase_q;
  assign run_en = (phase_q == PH_RUN);

  // R1: reset always lands in the loading phase
  a_r1_reset_load: assert property (@(posedge clk)
    !rst_n |=> (phase == PH_LOAD));

  // R2: a low mode level keeps the block loading
  a_r2_stay_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && !mode_q) |=> (phase == PH_LOAD));

  // R5: a registered high mode level moves loading to running
  a_r5_leave_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && mode_q) |=> (phase == PH_RUN));

  // R8: running is kept until reset
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN));
endmodule

// File: rtl/boot_port_mux.sv
module boot_port_mux
  import boot_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  boot_phase_e       phase,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    if (phase == PH_LOAD) begin
      sel_we   = 1'b1;
      sel_addr = ext_addr;
      sel_data = ext_data;
    end else begin
      sel_we   = core_we;
      sel_addr = core_addr;
      sel_data = core_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we    <= sel_we;
      ram_addr  <= sel_addr;
      ram_wdata <= sel_data;
    end
  end

  // R1: no write is issued in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!ram_we && ram_addr == '0 && ram_wdata == '0));

  // R3: loading registers the pin address and data with write enable set
  a_r3_load_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD) |=> (ram_we && ram_addr == $past(ext_addr)
                            && ram_wdata == $past(ext_data)));

  // R6: running passes the core port through one register stage
  a_r6_run_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (ram_we == $past(core_we) && ram_addr == $past(core_addr)
                           && ram_wdata == $past(core_wdata)));
endmodule

// File: rtl/boot_load_ctrl.sv
module boot_load_ctrl
  import boot_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              run_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  logic        mode_q;
  boot_phase_e phase;

  boot_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pin (mode_sel),
    .mode_q   (mode_q)
  );

  boot_phase_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_q (mode_q),
    .phase  (phase),
    .run_en (run_en)
  );

  boot_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .ext_addr   (ext_addr),
    .ext_data   (ext_data),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

  // R7: while running the pins cannot reach the port, so a port that
  // differs from the registered core values would expose a leak
  a_r7_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (ram_addr == $past(core_addr)));
endmodule

// File: tb/boot_load_ctrl_test.sv
module boot_load_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic [4:0] ext_addr = '0;
  logic [7:0] ext_data = '0;
  logic       core_we = 1'b0;
  logic [4:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic       run_en;
  logic       ram_we;
  logic [4:0] ram_addr;
  logic [7:0] ram_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  int unsigned seed = 32'h1234_5678;

  // behavioural reference state
  bit m_mode;
  bit m_run;
  bit m_we;
  int m_addr;
  int m_data;

  boot_load_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ext_addr(ext_addr), .ext_data(ext_data),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .run_en(run_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  always #5 clk = ~clk;

  function automatic int unsigned next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // advance one clock: update the model from the inputs now driven,
  // pass the rising edge, compare at the falling edge
  task automatic cycle();
    bit n_mode, n_run, n_we;
    int n_addr, n_data;
    if (!rst_n) begin
      n_mode = 0; n_run = 0; n_we = 0; n_addr = 0; n_data = 0;
    end else begin
      n_mode = mode_sel;
      n_run  = m_run | m_mode;
      if (m_run) begin
        n_we = core_we; n_addr = core_addr; n_data = core_wdata;
      end else begin
        n_we = 1; n_addr = ext_addr; n_data = ext_data;
      end
    end
    m_mode = n_mode; m_run = n_run; m_we = n_we; m_addr = n_addr; m_data = n_data;
    @(negedge clk);
    check("run_en", run_en, m_run);
    check("ram_we", ram_we, m_we);
    check("ram_addr", ram_addr, m_addr);
    check("ram_wdata", ram_wdata, m_data);
  endtask

  task automatic scramble_core();
    int unsigned r = next_rand();
    core_we    = r[0];
    core_addr  = r[5:1];
    core_wdata = r[13:6];
  endtask

  initial begin
    // R1: reset held for three edges
    tag = "R1";
    for (int i = 0; i < 3; i++) cycle();
    check("R1 run_en after reset", run_en, 0);
    check("R1 ram_we after reset", ram_we, 0);
    rst_n = 1'b1;

    // R3, R4: fill every address; core port toggles and must be ignored
    tag = "R3";
    for (int i = 0; i < 32; i++) begin
      if (i == 8) tag = "R4";
      ext_addr = i[4:0];
      ext_data = 8'((31 - i) * 7 + 3);
      scramble_core();
      cycle();
    end
    // R2: mode low, stay loading for a while with random pins
    tag = "R2";
    for (int i = 0; i < 10; i++) begin
      ext_addr = 5'(next_rand());
      ext_data = 8'(next_rand());
      cycle();
    end
    check("R2 still loading", run_en, 0);

    // R5: mode high, run_en after two edges; transition edge still writes
    tag = "R5";
    mode_sel = 1'b1;
    ext_addr = 5'd17; ext_data = 8'hA5;
    cycle();
    check("R5 run_en one edge after mode", run_en, 0);
    ext_addr = 5'd18; ext_data = 8'h5A;
    cycle();
    check("R5 run_en two edges after mode", run_en, 1);
    check("R5 last pin write addr", ram_addr, 18);

    // R6: core port passes through
    tag = "R6";
    for (int i = 0; i < 12; i++) begin
      scramble_core();
      cycle();
    end
    // R7: pins move, port follows only core
    tag = "R7";
    core_we = 1'b0; core_addr = 5'd3; core_wdata = 8'h3C;
    for (int i = 0; i < 8; i++) begin
      ext_addr = 5'(next_rand());
      ext_data = 8'(next_rand());
      cycle();
    end
    check("R7 port addr kept at core value", ram_addr, 3);
    check("R7 port data kept at core value", ram_wdata, 8'h3C);

    // R8: mode low while running changes nothing
    tag = "R8";
    mode_sel = 1'b0;
    for (int i = 0; i < 10; i++) begin
      scramble_core();
      ext_addr = 5'(next_rand());
      cycle();
    end
    check("R8 run_en kept", run_en, 1);

    // R9: reset while running, then loading resumes
    tag = "R9";
    rst_n = 1'b0;
    cycle();
    check("R9 run_en cleared", run_en, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ext_addr = 5'(i + 9);
      ext_data = 8'(i * 33);
      scramble_core();
      cycle();
    end
    check("R9 pin write resumed", ram_addr, 12);

    // R5: single-cycle pulse is enough
    tag = "R5";
    mode_sel = 1'b1;
    cycle();
    mode_sel = 1'b0;
    cycle();
    check("R5 pulse enters run", run_en, 1);
    for (int i = 0; i < 4; i++) begin
      scramble_core();
      cycle();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule